// File: doc/BRIEF.md
# FIFO Watermark Interrupt Controller

This block gathers the interrupt sources of a serial engine that moves data through a transmit FIFO and a receive FIFO. It compares the two FIFO fill levels against thresholds to raise a transmit-watermark request and a receive-watermark request. It also derives a ready-to-receive flow-control flag from the receive fill level. Eleven engine event lines are captured as sticky status bits. These lines cover command completion, final receive data, cancel and abort completion, and the command and FIFO error conditions.

Every status bit is held in one status vector. An enable mask selects which status bits may drive the single interrupt output. Software clears bits with a write-one-to-clear strobe. The two watermark bits are latched levels: a bit sets whenever its condition is true, stays set after the condition goes away, and comes straight back if it is cleared while the condition still holds. The event bits capture the rising edge of their input and hold until they are cleared.

Top module: `fifo_irq_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `status` is all zero and `irq` is low.
- R2: When `tx_wm_cfg` is non-zero and `tx_level <= tx_wm_cfg` at a clock edge, `status[0]` (transmit watermark) is 1 after that edge. When `tx_wm_cfg` is 0, this bit never sets.
- R3: When `rx_level >= DEPTH-3` at a clock edge, `status[1]` (receive watermark) is 1 after that edge.
- R4: `rx_ready` is 1 while `rx_level < DEPTH-2`, and 0 at or above that level.
- R5: A watermark bit stays set after its condition goes away, until it is cleared. A clear applied while the condition still holds leaves the bit at 1.
- R6: An event bit sets on a 0-to-1 transition of its `evt` line. An `evt` line held high after its bit is cleared does not set the bit again.
- R7: While `clr_we` is 1, each 1 in `clr_data` clears the matching status bit at the clock edge. Zeros in `clr_data` have no effect, and nothing is cleared while `clr_we` is 0.
- R8: If a set condition and a clear of the same bit meet in one cycle, the bit ends up set.
- R9: `irq` is 1 exactly when some status bit and its `ien` bit are both 1.
- R10: `evt[k]` maps to `status[k+2]`. The events, in `evt` order 0 to 10, are: command done, receive last, cancel done, abort done, command overrun, illegal command, command failure, receive-FIFO read error, receive-FIFO write error, transmit-FIFO read error, transmit-FIFO write error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_level | input | $clog2(DEPTH+1) | Transmit FIFO fill level in words |
| rx_level | input | $clog2(DEPTH+1) | Receive FIFO fill level in words |
| tx_wm_cfg | input | $clog2(DEPTH+1) | Transmit watermark threshold; 0 turns the source off |
| evt | input | 11 | Engine event lines, mapped as in R10 |
| ien | input | 13 | Interrupt enable mask, one bit per status bit |
| clr_we | input | 1 | Clear strobe |
| clr_data | input | 13 | Write-one-to-clear mask |
| status | output | 13 | Status vector |
| irq | output | 1 | Combined interrupt request |
| rx_ready | output | 1 | Receive flow-control flag |

## Verification
The checker tests several rules on every cycle. It checks that both watermark thresholds set their bit one edge later. It checks that each event rising edge shows up in its own status bit even when a clear hits that bit in the same cycle. It checks that a bit only falls when a clear strobe covered it, and that `irq` only rises with an enabled set bit. Some behaviour can only be shown by the bench's scenarios. This covers a watermark that refuses to clear while its level holds, the threshold-off setting, the ready flag's boundary, the exact bit position of each event, and a held event line that stays quiet after its bit is cleared.

// File: rtl/fifo_irq_pkg.sv
package fifo_irq_pkg;

    localparam int NUM_EVT  = 11;
    localparam int NUM_STAT = NUM_EVT + 2;

    typedef enum int {
        ST_TX_WM      = 0,
        ST_RX_WM      = 1,
        ST_CMD_DONE   = 2,
        ST_RX_LAST    = 3,
        ST_CANCEL     = 4,
        ST_ABORT      = 5,
        ST_OVERRUN    = 6,
        ST_ILLEGAL    = 7,
        ST_CMD_FAIL   = 8,
        ST_RXF_RD_ERR = 9,
        ST_RXF_WR_ERR = 10,
        ST_TXF_RD_ERR = 11,
        ST_TXF_WR_ERR = 12
    } stat_bit_e;

    typedef struct packed {
        logic rx_hit;
        logic tx_hit;
    } wm_hit_t;

    // receive watermark sits three words below full
    function automatic int rx_wm_level(int depth);
        return depth - 3;
    endfunction

    // ready-to-receive drops two words below full
    function automatic int rx_stop_level(int depth);
        return depth - 2;
    endfunction

endpackage

// File: rtl/fifo_irq_wm.sv
module fifo_irq_wm
    import fifo_irq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int LVL_W = 5
) (
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] tx_wm_cfg,
    output wm_hit_t          hits,
    output logic             rx_ready
);
    localparam logic [LVL_W-1:0] RX_TH   = LVL_W'(rx_wm_level(DEPTH));
    localparam logic [LVL_W-1:0] RX_STOP = LVL_W'(rx_stop_level(DEPTH));

    always_comb begin
        hits.tx_hit = (tx_wm_cfg != '0) && (tx_level <= tx_wm_cfg);
        hits.rx_hit = (rx_level >= RX_TH);
        rx_ready    = (rx_level < RX_STOP);
    end
endmodule

// File: rtl/fifo_irq_edge.sv
module fifo_irq_edge #(
    parameter int N = 11
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] evt,
    output logic [N-1:0] rise
);
    for (genvar g = 0; g < N; g++) begin : g_det
        logic last_q;
        always_ff @(posedge clk) begin
            if (rst) last_q <= 1'b0;
            else     last_q <= evt[g];
        end
        assign rise[g] = evt[g] & ~last_q;
    end
endmodule

// File: rtl/fifo_irq_stat.sv
module fifo_irq_stat #(
    parameter int N = 13
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    input  logic [N-1:0] ien,
    output logic [N-1:0] status,
    output logic         irq
);
    logic [N-1:0] stat_q;

    for (genvar g = 0; g < N; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)             stat_q[g] <= 1'b0;
            else if (set_vec[g]) stat_q[g] <= 1'b1;
            else if (clr_vec[g]) stat_q[g] <= 1'b0;
        end
    end

    assign status = stat_q;
    assign irq    = |(stat_q & ien);
endmodule

// File: rtl/fifo_irq_ctrl.sv
module fifo_irq_ctrl
    import fifo_irq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [$clog2(DEPTH+1)-1:0] tx_level,
    input  logic [$clog2(DEPTH+1)-1:0] rx_level,
    input  logic [$clog2(DEPTH+1)-1:0] tx_wm_cfg,
    input  logic [10:0]                evt,
    input  logic [12:0]                ien,
    input  logic                       clr_we,
    input  logic [12:0]                clr_data,
    output logic [12:0]                status,
    output logic                       irq,
    output logic                       rx_ready
);
    localparam int LVL_W = $clog2(DEPTH + 1);

    wm_hit_t               hits;
    logic [NUM_EVT-1:0]    rise;
    logic [NUM_STAT-1:0]   set_vec;
    logic [NUM_STAT-1:0]   clr_vec;

    fifo_irq_wm #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_wm (
        .tx_level (tx_level),
        .rx_level (rx_level),
        .tx_wm_cfg(tx_wm_cfg),
        .hits     (hits),
        .rx_ready (rx_ready)
    );

    fifo_irq_edge #(.N(NUM_EVT)) u_edge (
        .clk (clk),
        .rst (rst),
        .evt (evt),
        .rise(rise)
    );

    assign set_vec = {rise, hits.rx_hit, hits.tx_hit};
    assign clr_vec = clr_we ? clr_data : '0;

    fifo_irq_stat #(.N(NUM_STAT)) u_stat (
        .clk    (clk),
        .rst    (rst),
        .set_vec(set_vec),
        .clr_vec(clr_vec),
        .ien    (ien),
        .status (status),
        .irq    (irq)
    );
endmodule

// File: rtl/fifo_irq_ctrl_chk.sv
module fifo_irq_ctrl_chk #(
    parameter int DEPTH = 16
) (
    input logic                       clk,
    input logic                       rst,
    input logic [$clog2(DEPTH+1)-1:0] tx_level,
    input logic [$clog2(DEPTH+1)-1:0] rx_level,
    input logic [$clog2(DEPTH+1)-1:0] tx_wm_cfg,
    input logic [10:0]                evt,
    input logic [12:0]                ien,
    input logic                       clr_we,
    input logic [12:0]                clr_data,
    input logic [12:0]                status,
    input logic                       irq
);
    logic [12:0] kept;
    assign kept = status & ~(clr_we ? clr_data : 13'd0);

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (status == 13'd0)); // R1

    AST_TXWM_SET: assert property (@(posedge clk) disable iff (rst)
        ((tx_wm_cfg != 0) && (tx_level <= tx_wm_cfg)) |=> status[0]); // R2

    AST_RXWM_SET: assert property (@(posedge clk) disable iff (rst)
        (int'(rx_level) >= DEPTH - 3) |=> status[1]); // R3

    AST_ONLY_CLEAR_DROPS: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ((status & $past(kept)) == $past(kept))); // R7

    AST_IRQ_NEEDS_ENABLED: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> ((status & ien) != 13'd0)); // R9

    for (genvar g = 0; g < 11; g++) begin : g_evt
        AST_EDGE_SETS: assert property (@(posedge clk) disable iff (rst)
            $rose(evt[g]) |=> status[g+2]); // R6 R8 R10
    end
endmodule

bind fifo_irq_ctrl fifo_irq_ctrl_chk #(.DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tx_level (tx_level),
    .rx_level (rx_level),
    .tx_wm_cfg(tx_wm_cfg),
    .evt      (evt),
    .ien      (ien),
    .clr_we   (clr_we),
    .clr_data (clr_data),
    .status   (status),
    .irq      (irq)
);

// File: tb/fifo_irq_ctrl_test.sv
`timescale 1ns/1ps
module fifo_irq_ctrl_test;
    localparam int DEPTH = 16;
    localparam int LW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [LW-1:0] tx_level = LW'(8);
    logic [LW-1:0] rx_level = '0;
    logic [LW-1:0] tx_wm_cfg = '0;
    logic [10:0]   evt = '0;
    logic [12:0]   ien = '0;
    logic          clr_we = 1'b0;
    logic [12:0]   clr_data = '0;
    logic [12:0]   status;
    logic          irq;
    logic          rx_ready;

    int checks = 0;
    int errors = 0;

    bit [12:0] m_stat = '0;
    bit [10:0] m_prev = '0;

    always #4 clk = ~clk;

    fifo_irq_ctrl #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst(rst), .tx_level(tx_level), .rx_level(rx_level),
        .tx_wm_cfg(tx_wm_cfg), .evt(evt), .ien(ien), .clr_we(clr_we),
        .clr_data(clr_data), .status(status), .irq(irq), .rx_ready(rx_ready)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic clear(logic [12:0] mask);
        clr_we = 1'b1;
        clr_data = mask;
        step();
        clr_we = 1'b0;
        clr_data = '0;
    endtask

    // behavioural reference, updated on each rising edge
    always begin
        @(posedge clk);
        if (rst) begin
            m_stat = '0;
            m_prev = '0;
        end else begin
            bit [12:0] nxt;
            nxt = m_stat;
            if (clr_we) nxt = nxt & ~clr_data;
            if (tx_wm_cfg != 0 && int'(tx_level) <= int'(tx_wm_cfg)) nxt[0] = 1'b1;
            if (int'(rx_level) >= DEPTH - 3) nxt[1] = 1'b1;
            for (int k = 0; k < 11; k++)
                if (evt[k] && !m_prev[k]) nxt[k+2] = 1'b1;
            m_prev = evt;
            m_stat = nxt;
        end
        #1;
        chk("R5 status vs model", 32'(status), 32'(m_stat));
        chk("R9 irq vs model", 32'(irq), 32'(|(m_stat & ien)));
        chk("R4 rx_ready vs model", 32'(rx_ready), 32'(int'(rx_level) < DEPTH - 2));
    end

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) step();
        chk("R1 status in reset", 32'(status), 0);
        chk("R1 irq in reset", 32'(irq), 0);
        rst = 1'b0;
        step();
        chk("R1 status after reset", 32'(status), 0);
        chk("R4 ready when empty", 32'(rx_ready), 1);

        // transmit watermark
        tx_level = '0; tx_wm_cfg = '0;
        step(); step();
        chk("R2 threshold zero disables", 32'(status[0]), 0);
        tx_wm_cfg = LW'(4); tx_level = LW'(5);
        step();
        chk("R2 above threshold", 32'(status[0]), 0);
        tx_level = LW'(4);
        step();
        chk("R2 at threshold", 32'(status[0]), 1);
        tx_level = LW'(10);
        step();
        chk("R5 latched after level rises", 32'(status[0]), 1);
        clear(13'h0001);
        chk("R7 clear of tx watermark", 32'(status[0]), 0);
        tx_level = LW'(3);
        step();
        clear(13'h0001);
        chk("R5 clear while condition holds", 32'(status[0]), 1);
        tx_level = LW'(10); tx_wm_cfg = '0;
        clear(13'h0001);
        chk("R7 tx watermark cleared", 32'(status), 0);

        // receive watermark and ready flag
        rx_level = LW'(12);
        step();
        chk("R3 below receive threshold", 32'(status[1]), 0);
        chk("R4 ready at 12", 32'(rx_ready), 1);
        rx_level = LW'(13);
        step();
        chk("R3 at receive threshold", 32'(status[1]), 1);
        chk("R4 ready at 13", 32'(rx_ready), 1);
        rx_level = LW'(14);
        step();
        chk("R4 not ready at 14", 32'(rx_ready), 0);
        rx_level = LW'(16);
        step();
        chk("R4 not ready when full", 32'(rx_ready), 0);
        rx_level = '0;
        clear(13'h0002);
        chk("R7 rx watermark cleared", 32'(status), 0);

        // event bit positions
        for (int i = 0; i < 11; i++) begin
            evt = 11'(1 << i);
            step();
            evt = '0;
            chk("R10 event bit position", 32'(status), 32'(1 << (i + 2)));
            clear(13'h1FFF);
        end

        // held event line
        evt[0] = 1'b1;
        step();
        chk("R6 edge sets command done", 32'(status[2]), 1);
        clear(13'h0004);
        chk("R6 held line stays cleared", 32'(status[2]), 0);
        step();
        chk("R6 held line still quiet", 32'(status[2]), 0);
        evt[0] = 1'b0;
        step();

        // clear strobe rules
        evt[1] = 1'b1;
        step();
        evt[1] = 1'b0;
        clr_data = 13'h1FFF; clr_we = 1'b0;
        step();
        chk("R7 no clear without strobe", 32'(status[3]), 1);
        clr_data = '0; clr_we = 1'b1;
        step();
        clr_we = 1'b0;
        chk("R7 zero mask keeps bit", 32'(status[3]), 1);
        clear(13'h0008);
        chk("R7 one clears bit", 32'(status[3]), 0);

        // set beats clear
        evt[2] = 1'b1;
        step();
        evt[2] = 1'b0;
        step();
        evt[2] = 1'b1;
        clear(13'h0010);
        chk("R8 set wins over clear", 32'(status[4]), 1);
        evt[2] = 1'b0;
        clear(13'h0010);
        chk("R8 later clear works", 32'(status[4]), 0);

        // interrupt combination
        evt[3] = 1'b1;
        step();
        evt[3] = 1'b0;
        ien = '0;
        #1;
        chk("R9 masked source", 32'(irq), 0);
        ien = 13'h0040;
        #1;
        chk("R9 other source enabled", 32'(irq), 0);
        ien = 13'h0020;
        #1;
        chk("R9 enabled source", 32'(irq), 1);
        clear(13'h0020);
        chk("R9 irq drops after clear", 32'(irq), 0);
        step();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule